// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two 16-bit unsigned operands and a carry-in and returns a 16-bit sum and a carry-out. It never ripples a carry bit by bit and never builds generate/propagate lookahead terms. Instead, each bit position works out its result twice: once as if the incoming carry were 0, and once as if it were 1. Neighbouring groups are then joined in rounds. In each round the group width doubles, from 1 bit to 2, 4, 8 and 16. At each join, the carry leaving the lower group picks which of the upper group's two prepared results survives. The external carry-in makes the last choice, between the two full-width candidates.

The whole datapath is combinational. A capture register sits behind it so that the adder can run from a clock. A small control unit releases that register one edge after reset is removed. From then on the register loads on every edge, so each result appears one clock after its operands.

Top module: `cond_sum_adder`

## Requirements
- R1: One clock edge after the operands are sampled, {carryOut, sumOut} equals the 17-bit value opA + opB + carryIn, for any operand values.
- R2: sumOut[0] equals opA[0] XOR opB[0] XOR carryIn. The carry-in selects which of the two precomputed bit-0 results appears.
- R3: With opA all ones, opB zero and carryIn 1, the carry crosses all 16 positions. The result is sumOut 0x0000 and carryOut 1.
- R4: A carry raised below every merge boundary is carried into the upper group. The case is opA = 2^k - 1, opB = 1, carryIn 0 for k = 1..16, and it gives 2^k.
- R5: All-ones operands with carryIn 1 give sumOut 0xFFFF and carryOut 1. With carryIn 0 they give sumOut 0xFFFE and carryOut 1.
- R6: While rstN is low, sumOut and carryOut are 0. The first rising edge after rstN goes high does not load the register, so the outputs stay 0 until the second edge.
- R7: The outputs change only at a rising edge. A change on the operands between edges is not visible on sumOut or carryOut before the next edge.
- R8: Alternating patterns 0xAAAA + 0x5555 give 0xFFFF with carryOut 0 when carryIn is 0. They give 0x0000 with carryOut 1 when carryIn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture register |
| rstN | input | 1 | Active-low asynchronous reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Incoming carry |
| sumOut | output | 16 | Registered sum |
| carryOut | output | 1 | Registered carry-out |

## Verification
The hardest case to reach from the ports is a carry produced deep in a low group that must pass through every later merge. In that case the carry-1 hypothesis of each upper group is the one kept at every level, including the final choice made by the carry-in. Random operands almost never create such a chain. The stimulus therefore uses dedicated vectors: all ones plus a carry-in, and a sweep of 2^k - 1 plus one across every bit position. This sweep places the producing carry just below each merge boundary at the 2-, 4-, 8- and 16-bit widths. Random vectors then cover mixed selection patterns.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef struct packed {
    logic capture;
  } csa_strobe_t;

  function automatic int carryOffset(input int width, input int lvl);
    return 2 * width - ((2 * width) >> lvl);
  endfunction
endpackage

// File: rtl/csa_merge.sv
module csa_merge #(
  parameter int HALF = 1
) (
  input  logic [HALF-1:0]   loSumZ,
  input  logic [HALF-1:0]   loSumO,
  input  logic              loCarZ,
  input  logic              loCarO,
  input  logic [HALF-1:0]   hiSumZ,
  input  logic [HALF-1:0]   hiSumO,
  input  logic              hiCarZ,
  input  logic              hiCarO,
  output logic [2*HALF-1:0] mSumZ,
  output logic [2*HALF-1:0] mSumO,
  output logic              mCarZ,
  output logic              mCarO
);
  // Lower half passes through; its carry picks the upper hypothesis.
  always_comb begin
    mSumZ = {(loCarZ ? hiSumO : hiSumZ), loSumZ};
    mCarZ = loCarZ ? hiCarO : hiCarZ;
    mSumO = {(loCarO ? hiSumO : hiSumZ), loSumO};
    mCarO = loCarO ? hiCarO : hiCarZ;
  end
endmodule

// File: rtl/csa_ctrl.sv
module csa_ctrl
  import csa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output csa_strobe_t strobe
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb strobe.capture = armed;
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath
  import csa_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  csa_strobe_t      strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int LEVELS = $clog2(WIDTH);
  localparam int NCARRY = 2 * WIDTH - 1;

  wire [LEVELS:0][WIDTH-1:0] sumZ;
  wire [LEVELS:0][WIDTH-1:0] sumO;
  wire [NCARRY-1:0]          carZ;
  wire [NCARRY-1:0]          carO;

  // Level 0: per-bit results for carry-in 0 and carry-in 1.
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign sumZ[0][i] = opA[i] ^ opB[i];
    assign sumO[0][i] = ~(opA[i] ^ opB[i]);
    assign carZ[i]    = opA[i] & opB[i];
    assign carO[i]    = opA[i] | opB[i];
  end

  // Merge levels with doubling group width.
  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int GW   = 1 << l;
    localparam int HW   = GW / 2;
    localparam int NG   = WIDTH >> l;
    localparam int PREV = carryOffset(WIDTH, l - 1);
    localparam int CURR = carryOffset(WIDTH, l);
    for (genvar g = 0; g < NG; g++) begin : g_grp
      csa_merge #(.HALF(HW)) u_merge (
        .loSumZ (sumZ[l-1][g*GW +: HW]),
        .loSumO (sumO[l-1][g*GW +: HW]),
        .loCarZ (carZ[PREV + 2*g]),
        .loCarO (carO[PREV + 2*g]),
        .hiSumZ (sumZ[l-1][g*GW+HW +: HW]),
        .hiSumO (sumO[l-1][g*GW+HW +: HW]),
        .hiCarZ (carZ[PREV + 2*g + 1]),
        .hiCarO (carO[PREV + 2*g + 1]),
        .mSumZ  (sumZ[l][g*GW +: GW]),
        .mSumO  (sumO[l][g*GW +: GW]),
        .mCarZ  (carZ[CURR + g]),
        .mCarO  (carO[CURR + g])
      );
    end
  end

  // Final choice by the external carry-in.
  logic [WIDTH-1:0] sumNext;
  logic             carNext;
  always_comb begin
    sumNext = carryIn ? sumO[LEVELS] : sumZ[LEVELS];
    carNext = carryIn ? carO[NCARRY-1] : carZ[NCARRY-1];
  end

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumOut   <= '0;
        carryOut <= 1'b0;
      end else if (strobe.capture) begin
        sumOut   <= sumNext;
        carryOut <= carNext;
      end
    end
  end else begin : g_comb
    always_comb begin
      sumOut   = sumNext;
      carryOut = carNext;
    end
  end
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder
  import csa_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  csa_strobe_t strobe;

  csa_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  csa_datapath #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [1:0]     edges;
  logic [WIDTH:0] refTotal;

  always_comb refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            edges <= 2'd0;
    else if (edges != 3)  edges <= edges + 2'd1;
  end

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (edges >= 2) |-> ({carryOut, sumOut} == $past(refTotal))); // R1

  AST_BIT0_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (edges >= 2) |-> (sumOut[0] == $past(opA[0] ^ opB[0] ^ carryIn))); // R2

  AST_FULL_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (edges >= 2 && $past(&opA && opB == '0 && carryIn)) |-> (carryOut && sumOut == '0)); // R3

  AST_FIRST_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (edges == 1) |-> (sumOut == '0 && !carryOut)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (edges == 3 && $past({opA, opB, carryIn}) == $past({opA, opB, carryIn}, 2))
      |-> ($stable(sumOut) && $stable(carryOut))); // R7

  always_ff @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (sumOut == '0 && !carryOut); // R6
    end
  end
endmodule

bind cond_sum_adder csa_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_cond_sum_adder.sv
module tb_cond_sum_adder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = 16'h1234;
  logic [15:0] opB = 16'h1111;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  logic [16:0] lastExp = '0;

  always #4ns clk = ~clk;

  cond_sum_adder dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, confirm the old value holds, sample after the next rising edge.
  task automatic applyVec(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] exp;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    #1ns;
    check("R7", {carryOut, sumOut}, lastExp);
    @(negedge clk);
    check(req, {carryOut, sumOut}, exp);
    check("R2", {16'd0, sumOut[0]}, {16'd0, a[0] ^ b[0] ^ c});
    lastExp = exp;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R6", {carryOut, sumOut}, 17'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R6", {carryOut, sumOut}, 17'd0);
    @(negedge clk);
    check("R1", {carryOut, sumOut}, 17'h02345);
    lastExp = 17'h02345;
  endtask

  task automatic testCorners();
    applyVec("R1", 16'h0000, 16'h0000, 1'b0);
    applyVec("R1", 16'h0000, 16'h0000, 1'b1);
    applyVec("R3", 16'hFFFF, 16'h0000, 1'b1);
    applyVec("R3", 16'h0000, 16'hFFFF, 1'b1);
    applyVec("R5", 16'hFFFF, 16'hFFFF, 1'b1);
    applyVec("R5", 16'hFFFF, 16'hFFFF, 1'b0);
    applyVec("R8", 16'hAAAA, 16'h5555, 1'b0);
    applyVec("R8", 16'hAAAA, 16'h5555, 1'b1);
    applyVec("R8", 16'h5555, 16'h5555, 1'b0);
    applyVec("R8", 16'hAAAA, 16'hAAAA, 1'b1);
  endtask

  task automatic testBoundaries();
    for (int k = 1; k <= 16; k++) begin
      logic [16:0] ones;
      ones = (17'd1 << k) - 17'd1;
      applyVec("R4", ones[15:0], 16'h0001, 1'b0);
    end
  endtask

  task automatic testRandom();
    for (int n = 0; n < 10000; n++) begin
      applyVec("R1", 16'($urandom), 16'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testCorners();
    testBoundaries();
    testRandom();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule